// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits of a four-beat memory burst. When a burst starts, a load strobe captures the starting offset from the incoming low address bits. After that, each cycle in which the active-low advance input is asserted moves the offset to the next beat, and the beat count wraps after four beats. In any other cycle the offset holds, so the burst is suspended.

Two beat orders are available. In interleaved order the offset is the start value XOR the beat count. In linear order the offset is the start value plus the beat count, modulo four. The order-select input is a static configuration input. It is captured when a burst is loaded, so a change partway through a burst takes effect only at the next load. If the order pin is left unused, the parameter `USE_ORDER_PIN` set to 0 ties the block to interleaved order. This matches an unconnected pin pulled high.

Top module: `burst_offset_seq`

## Requirements
- R1: While `rstN` is low, and after it is released with no load, `offset` is 00. The captured order is interleaved.
- R2: A rising clock edge with `loadStrobe` high sets `offset` to `loadValue` right after that edge. The beat count returns to 0.
- R3: A rising edge with `loadStrobe` low and `advN` low moves the beat count to the next of 0,1,2,3. After beat 3 it wraps back to 0, which gives the start offset again.
- R4: A rising edge with `loadStrobe` low and `advN` high leaves `offset` unchanged.
- R5: When `loadStrobe` is high, the state of `advN` has no effect. The result is a plain load.
- R6: With interleaved order captured (`orderSel` = 1 at the load), `offset` is start XOR beat. From start 01 the offsets are 01, 00, 11, 10. From start 10 they are 10, 11, 00, 01.
- R7: With linear order captured (`orderSel` = 0 at the load), `offset` is start plus beat, modulo 4. From start 11 the offsets are 11, 00, 01, 10.
- R8: `orderSel` is sampled only on a load edge. Changes between loads do not alter the offsets of the burst in progress.
- R9: With `USE_ORDER_PIN` = 0, `orderSel` is ignored and every burst uses interleaved order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStrobe | input | 1 | Start a burst with `loadValue` |
| loadValue | input | OFFS_W | Starting offset (low address bits) |
| advN | input | 1 | Active-low advance to the next beat |
| orderSel | input | 1 | 1 = interleaved, 0 = linear; sampled at load |
| offset | output | OFFS_W | Current burst offset |

## Verification
The embedded properties check three things on every cycle:
- A load edge delivers the captured value on the next cycle, and a simultaneous advance is dropped.
- An idle edge holds the offset and the captured order.
- A linear step adds one, and an interleaved step flips exactly the bits that change in the beat count.

Three other behaviours show only in the bench scenarios, where a behavioural model is compared on every clock:
- Complete four-beat sequences from each start value in both orders, including the wrap back to the start.
- Suspension partway through a burst.
- The effect of changing the order pin during a burst, and of the tied-off variant.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Strobes passed from the control decode to the offset datapath.
  typedef struct packed {
    logic load;        // capture a new start offset and order
    logic step;        // advance to the next beat
    logic interleave;  // order to capture on load: 1 interleaved, 0 linear
  } seqStrobes_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter bit USE_ORDER_PIN = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadStrobe,
  input  logic                       advN,
  input  logic                       orderSel,
  output burst_seq_pkg::seqStrobes_t strobes
);

  logic orderEff;

  generate
    if (USE_ORDER_PIN) begin : g_orderPin
      assign orderEff = orderSel;
    end else begin : g_orderTied
      // An unused pin behaves as if pulled high: interleaved order.
      assign orderEff = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes            = '0;
    strobes.load       = loadStrobe;
    strobes.step       = !advN && !loadStrobe;  // a load wins over advance
    strobes.interleave = orderEff;
  end

  // R5: a load never goes out together with a step
  assert_load_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> (strobes.load && !strobes.step));

  // R9: the tied variant always asks for interleaved order
  assert_tied_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!USE_ORDER_PIN) |-> strobes.interleave);

endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath #(
  parameter int OFFS_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  burst_seq_pkg::seqStrobes_t strobes,
  input  logic [OFFS_W-1:0]          loadValue,
  output logic [OFFS_W-1:0]          offsetO
);

  logic [OFFS_W-1:0] startReg;
  logic [OFFS_W-1:0] beatReg;
  logic              orderReg;
  logic [OFFS_W-1:0] nextBeat;

  assign nextBeat = beatReg + 1'b1;  // wraps naturally at 2**OFFS_W

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      beatReg  <= '0;
      orderReg <= 1'b1;
    end else if (strobes.load) begin
      startReg <= loadValue;
      beatReg  <= '0;
      orderReg <= strobes.interleave;
    end else if (strobes.step) begin
      beatReg  <= nextBeat;
    end
  end

  always_comb begin
    if (orderReg) offsetO = startReg ^ beatReg;
    else          offsetO = startReg + beatReg;
  end

  // R2: a load shows its value on the following cycle
  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (offsetO == $past(loadValue)));

  // R4: no load and no step holds the offset
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(offsetO));

  // R8: the captured order changes only on a load
  assert_order_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(orderReg));

  // R7: a linear step adds one to the offset
  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !orderReg) |=> (offsetO == OFFS_W'($past(offsetO) + 1'b1)));

  // R6: an interleaved step flips exactly the bits that change in the beat count
  assert_interleave_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && orderReg) |=>
      ((offsetO ^ $past(offsetO)) == ($past(beatReg) ^ $past(nextBeat))));

  // R3: the beat count wraps to zero after the last beat
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && (beatReg == {OFFS_W{1'b1}})) |=> (beatReg == '0));

endmodule

// File: rtl/burst_offset_seq.sv
module burst_offset_seq #(
  parameter int OFFS_W        = 2,
  parameter bit USE_ORDER_PIN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStrobe,
  input  logic [OFFS_W-1:0] loadValue,
  input  logic              advN,
  input  logic              orderSel,
  output logic [OFFS_W-1:0] offset
);

  burst_seq_pkg::seqStrobes_t strobes;

  burst_seq_ctrl #(.USE_ORDER_PIN(USE_ORDER_PIN)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .advN       (advN),
    .orderSel   (orderSel),
    .strobes    (strobes)
  );

  burst_seq_datapath #(.OFFS_W(OFFS_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValue (loadValue),
    .offsetO   (offset)
  );

  // R1: the offset is zero on the first cycle after reset
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |=> (offset == '0));

endmodule

// File: tb/test_burst_offset_seq.sv
module test_burst_offset_seq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStrobe = 1'b0;
  logic [1:0] loadValue = 2'b00;
  logic       advN = 1'b1;
  logic       orderSel = 1'b1;
  logic [1:0] offset;
  logic [1:0] offsetTied;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state for the pin-controlled and tied instances
  int mStart = 0, mBeat = 0, mOrder = 1;
  int tStart = 0, tBeat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_offset_seq #(.OFFS_W(2), .USE_ORDER_PIN(1'b1)) i_burst_offset_seq (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .loadValue(loadValue),
    .advN(advN), .orderSel(orderSel), .offset(offset));

  burst_offset_seq #(.OFFS_W(2), .USE_ORDER_PIN(1'b0)) i_burst_offset_seq_tied (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .loadValue(loadValue),
    .advN(advN), .orderSel(orderSel), .offset(offsetTied));

  function automatic int expOffset(int s, int b, int ord);
    if (ord != 0) return (s ^ b) & 3;
    return (s + b) % 4;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, update the model at the rising edge,
  // and compare both instances at the next falling edge.
  task automatic cyc(string tag, bit ld, int val, bit adv, bit ord);
    loadStrobe = ld; loadValue = 2'(val); advN = adv; orderSel = ord;
    @(posedge clk);
    if (!rstN) begin
      mStart = 0; mBeat = 0; mOrder = 1; tStart = 0; tBeat = 0;
    end else if (ld) begin
      mStart = val; mBeat = 0; mOrder = ord; tStart = val; tBeat = 0;
    end else if (!adv) begin
      mBeat = (mBeat + 1) % 4; tBeat = (tBeat + 1) % 4;
    end
    @(negedge clk);
    check({tag, " pin"}, int'(offset), expOffset(mStart, mBeat, mOrder));
    check({tag, " R9 tied"}, int'(offsetTied), expOffset(tStart, tBeat, 1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual %0d expected %0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc("R1 reset", 1'b0, 0, 1'b0, 1'b0);
    cyc("R1 reset", 1'b0, 0, 1'b1, 1'b0);
    rstN = 1'b1;
    cyc("R1 idle after reset", 1'b0, 0, 1'b1, 1'b1);

    // R6: interleaved order from 01 gives 01,00,11,10 and then wraps (R3)
    cyc("R2 load 01", 1'b1, 1, 1'b1, 1'b1);
    check("R6 seq 01 beat0", int'(offset), 1);
    cyc("R6 step", 1'b0, 0, 1'b0, 1'b1);
    check("R6 seq 01 beat1", int'(offset), 0);
    cyc("R6 step", 1'b0, 0, 1'b0, 1'b1);
    check("R6 seq 01 beat2", int'(offset), 3);
    cyc("R6 step", 1'b0, 0, 1'b0, 1'b1);
    check("R6 seq 01 beat3", int'(offset), 2);
    cyc("R3 wrap", 1'b0, 0, 1'b0, 1'b1);
    check("R3 wrap to start", int'(offset), 1);

    // R6: interleaved order from 10, with a suspension (R4)
    cyc("R2 load 10", 1'b1, 2, 1'b1, 1'b1);
    cyc("R6 step", 1'b0, 0, 1'b0, 1'b1);
    check("R6 seq 10 beat1", int'(offset), 3);
    cyc("R4 hold", 1'b0, 0, 1'b1, 1'b1);
    cyc("R4 hold", 1'b0, 0, 1'b1, 1'b1);
    check("R4 held", int'(offset), 3);
    cyc("R6 step", 1'b0, 0, 1'b0, 1'b1);
    check("R6 seq 10 beat2", int'(offset), 0);
    cyc("R6 step", 1'b0, 0, 1'b0, 1'b1);
    check("R6 seq 10 beat3", int'(offset), 1);

    // R7: linear order from 11 gives 11,00,01,10; R8: the pin toggles mid-burst
    cyc("R2 load 11 linear", 1'b1, 3, 1'b1, 1'b0);
    check("R7 seq 11 beat0", int'(offset), 3);
    cyc("R8 step pin high", 1'b0, 0, 1'b0, 1'b1);
    check("R7 seq 11 beat1", int'(offset), 0);
    cyc("R8 step pin high", 1'b0, 0, 1'b0, 1'b1);
    check("R8 seq 11 beat2 stays linear", int'(offset), 1);
    cyc("R7 step", 1'b0, 0, 1'b0, 1'b0);
    check("R7 seq 11 beat3", int'(offset), 2);
    cyc("R3 wrap linear", 1'b0, 0, 1'b0, 1'b0);
    check("R3 linear wrap", int'(offset), 3);

    // R5: a load with advance asserted is a plain load, beat 0
    cyc("R5 step first", 1'b0, 0, 1'b0, 1'b0);
    cyc("R5 load with adv", 1'b1, 1, 1'b0, 1'b0);
    check("R5 load wins", int'(offset), 1);
    cyc("R5 next step", 1'b0, 0, 1'b0, 1'b0);
    check("R5 then beat1 linear", int'(offset), 2);
    check("R9 tied interleaved", int'(offsetTied), 0);

    // Every start value in both orders, all beats compared against the model
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        cyc("R2 sweep load", 1'b1, s, 1'b1, ord[0]);
        for (int b = 0; b < 5; b++) cyc("R3 R6 R7 sweep step", 1'b0, 0, 1'b0, ord[0]);
      end
    end

    // R1: reset in the middle of a burst
    cyc("R1 pre", 1'b1, 2, 1'b1, 1'b0);
    rstN = 1'b0;
    cyc("R1 mid reset", 1'b0, 0, 1'b0, 1'b0);
    rstN = 1'b1;
    cyc("R1 after reset step", 1'b0, 0, 1'b0, 1'b0);
    check("R1 interleave default after reset", int'(offset), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule